// File: doc/BRIEF.md
# Banked Logical-to-Physical Address Translator

This block widens a 16-bit processor logical address into a 20-bit physical address. It splits the logical space into as many as three regions at 4 KB granularity. The lowest region maps straight through. Each of the two upper regions adds its own programmable base, expressed in 4 KB pages, to the logical address. Three 8-bit control registers hold the configuration, and the processor reads and writes them through a small I/O port interface.

The boundary register holds two 4-bit page numbers. Its low nibble is the first page of the banked region and its high nibble is the first page of the upper common region. Two base registers, one per upper region, supply the page offsets. A parameter selects one of two output timings: combinational, or registered with one cycle of latency.

Top module: `bank_xlate`

## Requirements
- R1: After reset the boundary register reads 0xF0 and both base registers read 0x00.
- R2: With the reset configuration every logical address maps to the same physical address, zero-extended (for example 0x1000 to 0x01000 and 0xF800 to 0x0F800).
- R3: A logical address whose top nibble is below both the low nibble (bank start) and the high nibble (upper start) of the boundary register maps to its zero-extended value.
- R4: A logical address whose top nibble is at or above the bank start and below the upper start maps to logical + bank base × 4096, and bits [11:0] pass through unchanged.
- R5: A logical address whose top nibble is at or above the upper start maps to logical + upper base × 4096. A boundary of 0x00 therefore sends the whole space to the upper region.
- R6: The sum is taken modulo 2^20, so a result above 0xFFFFF wraps to the bottom of physical memory.
- R7: The port addresses are 0x00 for the upper base, 0x01 for the bank base and 0x02 for the boundary. A read with io_rd high returns the stored value. io_rdata is 0 when io_rd is low or the address is unmapped, and a write to an unmapped address changes nothing.
- R8: A register write is captured at the clock edge where io_wr is high and affects translation from the following cycle on.
- R9: If the upper start is below the bank start, the upper-region comparison takes priority: pages at or above the upper start use the upper base, and all lower pages map straight through.
- R10: With LATENCY = 0, phys_addr follows log_addr in the same cycle. With LATENCY = 1 it shows the translation of the log_addr present at the previous clock edge, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | IO_AW (8) | Control port address |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_wdata | input | REG_W (8) | Port write data |
| io_rdata | output | REG_W (8) | Port read data |
| log_addr | input | LA_W (16) | Logical address |
| phys_addr | output | PA_W (20) | Translated physical address |

## Verification
Read data and the combinational translation settle in the same cycle as their inputs. The registered translation appears one edge later, and a register write shows only after the edge that captures it. The bench drives every input on the falling edge and samples 1 ns later. A combinational result is therefore read in the half-cycle its input was applied, and a registered or written result only after one rising edge has passed. Two instances, one per latency setting, share the stimulus. This lets the bench check directly both the one-cycle lag and the write that takes effect on the next cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   typedef enum logic [1:0] {
      AREA_LOW  = 2'd0,
      AREA_BANK = 2'd1,
      AREA_HIGH = 2'd2
   } area_e;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs #(
   parameter int IO_AW = 8,
   parameter int REG_W = 8,
   parameter logic [IO_AW-1:0] PORT_HIGH  = 'h0,
   parameter logic [IO_AW-1:0] PORT_BANK  = 'h1,
   parameter logic [IO_AW-1:0] PORT_BOUND = 'h2,
   parameter logic [REG_W-1:0] BOUND_RST  = 'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [REG_W-1:0] io_wdata,
   output logic [REG_W-1:0] io_rdata,
   output logic [REG_W-1:0] high_base,
   output logic [REG_W-1:0] bank_base,
   output logic [REG_W-1:0] boundary
);
   localparam int NREG = 3;
   localparam logic [IO_AW-1:0] PORT_MAP [NREG] = '{PORT_HIGH, PORT_BANK, PORT_BOUND};

   if (PORT_HIGH == PORT_BANK || PORT_HIGH == PORT_BOUND || PORT_BANK == PORT_BOUND) begin : g_bad_ports
      $error("xlate_regs: control port addresses must differ");
   end

   logic [REG_W-1:0] reg_q [NREG];
   logic [NREG-1:0]  hit;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [REG_W-1:0] RST_VAL = (i == NREG-1) ? BOUND_RST : '0;
      assign hit[i] = (io_addr == PORT_MAP[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reg_q[i] <= RST_VAL;
         else if (io_wr && hit[i])
            reg_q[i] <= io_wdata;
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_rd) begin
         for (int k = 0; k < NREG; k++)
            if (hit[k]) io_rdata = reg_q[k];
      end
   end

   assign high_base = reg_q[0];
   assign bank_base = reg_q[1];
   assign boundary  = reg_q[2];
endmodule

// File: rtl/xlate_area.sv
module xlate_area
   import xlate_pkg::*;
#(
   parameter int LA_W  = 16,
   parameter int NIB_W = 4
) (
   input  logic [LA_W-1:0]    log_addr,
   input  logic [2*NIB_W-1:0] boundary,
   output area_e              area
);
   logic [NIB_W-1:0] page, bank_start, high_start;

   assign page       = log_addr[LA_W-1 -: NIB_W];
   assign bank_start = boundary[NIB_W-1:0];
   assign high_start = boundary[2*NIB_W-1 -: NIB_W];

   // Upper comparison first, so a reversed boundary still decodes cleanly
   always_comb begin
      if (page >= high_start)
         area = AREA_HIGH;
      else if (page >= bank_start)
         area = AREA_BANK;
      else
         area = AREA_LOW;
   end
endmodule

// File: rtl/xlate_sum.sv
module xlate_sum #(
   parameter int LA_W    = 16,
   parameter int PA_W    = 20,
   parameter int PAGE_W  = 12,
   parameter int BASE_W  = 8,
   parameter int LATENCY = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   log_addr,
   input  logic [BASE_W-1:0] base,
   output logic [PA_W-1:0]   phys_addr
);
   localparam int HI_W = PA_W - PAGE_W;

   if (HI_W != BASE_W) begin : g_bad_width
      $error("xlate_sum: base width must cover the physical page number");
   end
   if (LATENCY != 0 && LATENCY != 1) begin : g_bad_lat
      $error("xlate_sum: LATENCY must be 0 or 1");
   end

   // Only the page number is added; the offset bypasses the adder
   logic [HI_W-1:0] hi_sum;
   logic [PA_W-1:0] sum;

   assign hi_sum = HI_W'(log_addr[LA_W-1:PAGE_W]) + base;
   assign sum    = {hi_sum, log_addr[PAGE_W-1:0]};

   if (LATENCY == 0) begin : g_comb
      assign phys_addr = sum;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phys_addr <= '0;
         else        phys_addr <= sum;
      end
   end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
   import xlate_pkg::*;
#(
   parameter int LA_W    = 16,
   parameter int PA_W    = 20,
   parameter int REG_W   = 8,
   parameter int IO_AW   = 8,
   parameter logic [IO_AW-1:0] PORT_HIGH  = 'h0,
   parameter logic [IO_AW-1:0] PORT_BANK  = 'h1,
   parameter logic [IO_AW-1:0] PORT_BOUND = 'h2,
   parameter int LATENCY = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic             io_rd,
   input  logic [REG_W-1:0] io_wdata,
   output logic [REG_W-1:0] io_rdata,
   input  logic [LA_W-1:0]  log_addr,
   output logic [PA_W-1:0]  phys_addr
);
   localparam int NIB_W  = REG_W / 2;
   localparam int PAGE_W = LA_W - NIB_W;
   localparam logic [REG_W-1:0] BOUND_RST = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};

   if (PA_W != PAGE_W + REG_W || PA_W <= LA_W || (REG_W % 2) != 0) begin : g_bad_geom
      $error("bank_xlate: inconsistent address or register widths");
   end

   logic [REG_W-1:0] high_q, bank_q, bound_q, base;
   area_e            area;

   xlate_regs #(
      .IO_AW(IO_AW), .REG_W(REG_W),
      .PORT_HIGH(PORT_HIGH), .PORT_BANK(PORT_BANK), .PORT_BOUND(PORT_BOUND),
      .BOUND_RST(BOUND_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .high_base(high_q), .bank_base(bank_q), .boundary(bound_q)
   );

   xlate_area #(.LA_W(LA_W), .NIB_W(NIB_W)) u_area (
      .log_addr(log_addr), .boundary(bound_q), .area(area)
   );

   always_comb begin
      unique case (area)
         AREA_HIGH: base = high_q;
         AREA_BANK: base = bank_q;
         default:   base = '0;
      endcase
   end

   xlate_sum #(
      .LA_W(LA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .BASE_W(REG_W), .LATENCY(LATENCY)
   ) u_sum (
      .clk(clk), .rst_n(rst_n),
      .log_addr(log_addr), .base(base), .phys_addr(phys_addr)
   );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
   parameter int LA_W    = 16,
   parameter int PA_W    = 20,
   parameter int REG_W   = 8,
   parameter int IO_AW   = 8,
   parameter logic [IO_AW-1:0] PORT_BOUND = 'h2,
   parameter int LATENCY = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IO_AW-1:0] io_addr,
   input logic             io_wr,
   input logic             io_rd,
   input logic [REG_W-1:0] io_wdata,
   input logic [REG_W-1:0] io_rdata,
   input logic [LA_W-1:0]  log_addr,
   input logic [PA_W-1:0]  phys_addr,
   input logic [REG_W-1:0] high_q,
   input logic [REG_W-1:0] bank_q,
   input logic [REG_W-1:0] bound_q
);
   localparam int NIB_W  = REG_W / 2;
   localparam int PAGE_W = LA_W - NIB_W;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   wire [NIB_W-1:0] page = log_addr[LA_W-1 -: NIB_W];

   // R1
   reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bound_q == {{NIB_W{1'b1}}, {NIB_W{1'b0}}} && high_q == '0 && bank_q == '0));

   // R7
   reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> ($stable(high_q) && $stable(bank_q) && $stable(bound_q)));

   // R8
   bound_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_BOUND) |=> (bound_q == $past(io_wdata)));

   // R7
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '0));

   if (LATENCY == 0) begin : g_comb_chk
      // R4
      offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         phys_addr[PAGE_W-1:0] == log_addr[PAGE_W-1:0]);
      // R3
      low_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (page < bound_q[NIB_W-1:0] && page < bound_q[REG_W-1 -: NIB_W])
            |-> (phys_addr == PA_W'(log_addr)));
   end else begin : g_reg_chk
      // R10
      offset_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (phys_addr[PAGE_W-1:0] == $past(log_addr[PAGE_W-1:0])));
   end
endmodule

bind bank_xlate xlate_chk #(
   .LA_W(LA_W), .PA_W(PA_W), .REG_W(REG_W), .IO_AW(IO_AW),
   .PORT_BOUND(PORT_BOUND), .LATENCY(LATENCY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .log_addr(log_addr),
   .phys_addr(phys_addr), .high_q(high_q), .bank_q(bank_q), .bound_q(bound_q)
);

// File: tb/tb_bank_xlate.sv
`timescale 1ns/1ps
module tb_bank_xlate;
   localparam logic [7:0] P_HIGH = 8'h00, P_BANK = 8'h01, P_BOUND = 8'h02;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = '0, io_wdata = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  rdata_c, rdata_q;
   logic [15:0] log_addr = '0;
   logic [19:0] pa_c, pa_q;

   int applied = 0;
   int miscmp  = 0;

   always #10 clk = ~clk;

   bank_xlate #(.LATENCY(0)) dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(rdata_c), .log_addr(log_addr), .phys_addr(pa_c));

   bank_xlate #(.LATENCY(1)) dut_q (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(rdata_q), .log_addr(log_addr), .phys_addr(pa_q));

   // {tag, boundary, bank base, upper base, logical, expected physical}
   localparam int NV = 15;
   localparam logic [67:0] VEC [NV] = '{
      {8'd2, 8'hF0, 8'h00, 8'h00, 16'h1000, 20'h01000},   // R2
      {8'd2, 8'hF0, 8'h00, 8'h00, 16'hF800, 20'h0F800},   // R2
      {8'd3, 8'h84, 8'h10, 8'h20, 16'h3ABC, 20'h03ABC},   // R3
      {8'd4, 8'h84, 8'h10, 8'h20, 16'h4000, 20'h14000},   // R4
      {8'd4, 8'h84, 8'h10, 8'h20, 16'h7FFF, 20'h17FFF},   // R4
      {8'd5, 8'h84, 8'h10, 8'h20, 16'h8000, 20'h28000},   // R5
      {8'd5, 8'h84, 8'h10, 8'h20, 16'hFFFF, 20'h2FFFF},   // R5
      {8'd5, 8'h00, 8'h55, 8'h30, 16'h0123, 20'h30123},   // R5 upper region only
      {8'd4, 8'h80, 8'h05, 8'h00, 16'h0000, 20'h05000},   // R4 no low region
      {8'd3, 8'h66, 8'hAA, 8'h40, 16'h5FFF, 20'h05FFF},   // R3 no bank region
      {8'd6, 8'hF0, 8'hFF, 8'h00, 16'h2345, 20'h01345},   // R6 bank wrap
      {8'd6, 8'hE0, 8'h00, 8'hFF, 16'hF000, 20'h0E000},   // R6 upper wrap
      {8'd9, 8'h2A, 8'h11, 8'h22, 16'h3000, 20'h25000},   // R9
      {8'd9, 8'h2A, 8'h11, 8'h22, 16'h1000, 20'h01000},   // R9
      {8'd9, 8'h2A, 8'h11, 8'h22, 16'hB000, 20'h2D000}    // R9
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      applied++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 v = rdata_c;
      io_rd = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      #1 check("R10 registered output in reset", 32'(pa_q), 32'h0);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      rd(P_BOUND, v); check("R1 boundary", 32'(v), 32'hF0);
      rd(P_BANK, v);  check("R1 bank base", 32'(v), 32'h00);
      rd(P_HIGH, v);  check("R1 upper base", 32'(v), 32'h00);

      // R2 identity after reset
      @(negedge clk) log_addr = 16'h1234;
      #1 check("R2 identity comb", 32'(pa_c), 32'h01234);
      @(negedge clk); #1 check("R2 identity reg", 32'(pa_q), 32'h01234);

      for (int i = 0; i < NV; i++) begin
         wr(P_BOUND, VEC[i][59:52]);
         wr(P_BANK,  VEC[i][51:44]);
         wr(P_HIGH,  VEC[i][43:36]);
         @(negedge clk) log_addr = VEC[i][35:20];
         @(negedge clk);
         #1;
         check($sformatf("R%0d vector %0d comb", VEC[i][67:60], i), 32'(pa_c), 32'(VEC[i][19:0]));
         check($sformatf("R%0d vector %0d reg", VEC[i][67:60], i), 32'(pa_q), 32'(VEC[i][19:0]));
      end

      // R7 readback of the last programmed values
      rd(P_BOUND, v); check("R7 boundary readback", 32'(v), 32'h2A);
      rd(P_BANK, v);  check("R7 bank readback", 32'(v), 32'h11);
      rd(P_HIGH, v);  check("R7 upper readback", 32'(v), 32'h22);

      // R8 write takes effect the cycle after its edge
      wr(P_BOUND, 8'h80);
      wr(P_BANK, 8'h00);
      @(negedge clk) log_addr = 16'h4000;
      @(negedge clk);
      io_addr = P_BANK; io_wdata = 8'h03; io_wr = 1'b1;
      #1 check("R8 before write edge", 32'(pa_c), 32'h04000);
      @(negedge clk) io_wr = 1'b0;
      #1 check("R8 after write edge", 32'(pa_c), 32'h07000);
      check("R10 registered lags write", 32'(pa_q), 32'h04000);
      @(negedge clk); #1 check("R10 registered catches up", 32'(pa_q), 32'h07000);

      // R10 address change latency
      @(negedge clk) log_addr = 16'h5000;
      #1 check("R10 comb same cycle", 32'(pa_c), 32'h08000);
      check("R10 registered holds old", 32'(pa_q), 32'h07000);
      @(negedge clk); #1 check("R10 registered next cycle", 32'(pa_q), 32'h08000);

      // R7 unmapped port is ignored and reads zero
      wr(8'h03, 8'h5A);
      rd(8'h03, v);   check("R7 unmapped read", 32'(v), 32'h00);
      rd(P_BOUND, v); check("R7 boundary untouched", 32'(v), 32'h80);
      rd(P_BANK, v);  check("R7 bank untouched", 32'(v), 32'h03);
      rd(P_HIGH, v);  check("R7 upper untouched", 32'(v), 32'h22);
      #1 check("R7 translation untouched", 32'(pa_c), 32'h08000);
      check("R7 idle read data", 32'(rdata_c), 32'h00);

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
   end
endmodule